// File: doc/BRIEF.md
# Trace Message Generator with Periodic Sync

This block sits beside a processor core and turns two event streams into a single stream of trace messages. Taken branches, each given as a source and target address, become program-flow messages. Loads and stores, each given as a direction, address and data word, become data messages. Program-flow messages come in two forms. A sync message carries the whole target address. A compressed message carries only the difference from the last target that was reported, so a decoder needs a sync message from time to time to keep its place. A programmable period controls how sync and compressed messages are interleaved. That period can also make every branch message a sync message.

Collection is started and stopped by strobes from a breakpoint unit. While collection is off, a single-capture strobe from a matched data breakpoint can still force out one data message for the access it flags. A 3-bit mode selects what the data messages report for each access direction: addresses, data, or both. Results leave through one output register with a valid/ready handshake. When that register is stalled, new events are dropped rather than queued. A sticky overflow flag records the loss, and the next branch message is forced to be a sync message.

Top module: `trace_msg_gen`

## Requirements
- R1: After reset, msg_valid_o and ovf_o are 0, collection is off, and a sync message is pending for the first branch.
- R2: trc_on_i switches collection on and trc_off_i switches it off, with off winning if both are high. The new state applies to events from the next cycle on. While collection is off, branches produce nothing, and data accesses produce nothing unless R9 applies.
- R3: While cfg_br_en_i is 0, no branch message (kind 1 or 2) is produced.
- R4: The first branch message after reset, and the first after collection switches from off to on, is a sync message. The period count restarts from it.
- R5: cfg_sync_sel_i sets the sync period: 0 makes every branch message a sync message, and 1, 2 and 3 make every 4th, 16th or 64th branch message a sync message, with the ones between them compressed.
- R6: A sync message has kind 1, msg_addr_o equal to the full branch target and msg_data_o equal to the branch source.
- R7: A compressed message has kind 2, msg_addr_o equal to the target minus the last reported target (modulo 2^32) and msg_data_o equal to the source.
- R8: cfg_data_mode_i selects the data messages: 0 none; 1 read address (kind 3); 2 write address (kind 4); 3 read and write addresses (kinds 3, 4); 4 read data only (kind 5); 5 read address and data (kind 6); 6 write address and data (kind 7); 7 read and write address and data (kinds 6, 7). Directions not listed for a mode produce nothing. A field that is not reported reads 0: kinds 3 and 4 put the address in msg_addr_o, kind 5 puts the data in msg_data_o, and kinds 6 and 7 carry both.
- R9: While collection is off, mem_valid_i together with single_i produces exactly one message for that access: kind 6 for a read or kind 7 for a write, carrying address and data in any mode. While collection is on, single_i has no effect.
- R10: A message appears in the cycle after its event is accepted. While msg_valid_o is 1 and msg_ready_i is 0, the message holds unchanged.
- R11: An event that would produce a message while the output register is stalled is dropped, and ovf_o sets and stays set. The next branch message is then a sync message, and loading it clears ovf_o.
- R12: A branch and a traced data access in the same cycle keep the branch, drop the data message and set ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_br_en_i | input | 1 | Enables branch messages |
| cfg_sync_sel_i | input | 2 | Sync period select (0 every, 1 /4, 2 /16, 3 /64) |
| cfg_data_mode_i | input | 3 | Data trace mode |
| trc_on_i | input | 1 | Collection-on strobe |
| trc_off_i | input | 1 | Collection-off strobe |
| single_i | input | 1 | Single-capture strobe for the current access |
| br_valid_i | input | 1 | Taken-branch event |
| br_src_i | input | 32 | Branch source address |
| br_tgt_i | input | 32 | Branch target address |
| mem_valid_i | input | 1 | Data access event |
| mem_write_i | input | 1 | 1 for a store, 0 for a load |
| mem_addr_i | input | 32 | Access address |
| mem_data_i | input | 32 | Access data |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_valid_o | output | 1 | Message present |
| msg_kind_o | output | 3 | Message kind |
| msg_addr_o | output | 32 | Address or address delta |
| msg_data_o | output | 32 | Source address or data word |
| ovf_o | output | 1 | Sticky drop flag |

## Verification
Every message comes from a single register stage, so it shows at the ports one clock edge after its event. The bench drives each event on a falling edge and reads the result on the next falling edge. A strobe on trc_on_i or trc_off_i takes effect one edge later, so the bench gives each strobe a cycle of its own before the events it governs. A stalled message must stay unchanged for every cycle that msg_ready_i is low. A drop shows on ovf_o in the same cycle as the message it lost to, and the forced sync message appears on the first branch after the stall clears.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_BR_SYNC = 3'd1,
    K_BR_COMP = 3'd2,
    K_RD_ADDR = 3'd3,
    K_WR_ADDR = 3'd4,
    K_RD_DATA = 3'd5,
    K_RD_AD   = 3'd6,
    K_WR_AD   = 3'd7
  } msg_kind_e;

  typedef enum logic [1:0] {
    SYNC_ALL = 2'd0,
    SYNC_4   = 2'd1,
    SYNC_16  = 2'd2,
    SYNC_64  = 2'd3
  } sync_sel_e;
endpackage

// File: rtl/trace_coll_ctrl.sv
module trace_coll_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  output logic coll_o,
  output logic start_o
);
  logic coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    coll_q <= 1'b0;
    else if (off_i) coll_q <= 1'b0;
    else if (on_i)  coll_q <= 1'b1;
  end

  assign coll_o  = coll_q;
  assign start_o = on_i && !off_i && !coll_q;
endmodule

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl #(
  parameter int unsigned CNT_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  input  logic       ovf_i,
  input  logic       br_load_i,
  output logic       is_sync_o
);
  import trace_pkg::*;

  logic [CNT_W-1:0] cnt_q, last_m1;
  logic             force_q;

  always_comb begin
    unique case (sync_sel_e'(sel_i))
      SYNC_4:  last_m1 = CNT_W'(3);
      SYNC_16: last_m1 = CNT_W'(15);
      SYNC_64: last_m1 = CNT_W'(63);
      default: last_m1 = '0;
    endcase
  end

  assign is_sync_o = (sync_sel_e'(sel_i) == SYNC_ALL) || force_q || ovf_i
                     || (cnt_q >= last_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      force_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q   <= '0;
      force_q <= 1'b1;
    end else if (br_load_i) begin
      force_q <= 1'b0;
      cnt_q   <= is_sync_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/trace_data_filter.sv
module trace_data_filter (
  input  logic       coll_i,
  input  logic       single_i,
  input  logic       write_i,
  input  logic [2:0] mode_i,
  output logic [2:0] kind_o
);
  import trace_pkg::*;

  msg_kind_e k;

  always_comb begin
    k = K_NONE;
    if (!coll_i) begin
      if (single_i) k = write_i ? K_WR_AD : K_RD_AD;
    end else begin
      unique case (mode_i)
        3'd1: k = write_i ? K_NONE    : K_RD_ADDR;
        3'd2: k = write_i ? K_WR_ADDR : K_NONE;
        3'd3: k = write_i ? K_WR_ADDR : K_RD_ADDR;
        3'd4: k = write_i ? K_NONE    : K_RD_DATA;
        3'd5: k = write_i ? K_NONE    : K_RD_AD;
        3'd6: k = write_i ? K_WR_AD   : K_NONE;
        3'd7: k = write_i ? K_WR_AD   : K_RD_AD;
        default: k = K_NONE;
      endcase
    end
  end

  assign kind_o = k;
endmodule

// File: rtl/trace_msg_gen.sv
module trace_msg_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_br_en_i,
  input  logic [1:0]        cfg_sync_sel_i,
  input  logic [2:0]        cfg_data_mode_i,
  input  logic              trc_on_i,
  input  logic              trc_off_i,
  input  logic              single_i,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_src_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic              mem_valid_i,
  input  logic              mem_write_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              msg_ready_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_kind_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  output logic              ovf_o
);
  import trace_pkg::*;

  localparam int unsigned PAY_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

  logic              coll, start, is_sync;
  logic [2:0]        dt_kind;
  logic              slot_free, br_req, dt_req, br_load, dt_load, drop;
  logic              valid_q, ovf_q;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q, last_tgt_q;
  logic [DATA_W-1:0] data_q;

  trace_coll_ctrl i_coll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .on_i    (trc_on_i),
    .off_i   (trc_off_i),
    .coll_o  (coll),
    .start_o (start)
  );

  trace_sync_ctrl #(.CNT_W(CNT_W)) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (cfg_sync_sel_i),
    .restart_i (start),
    .ovf_i     (ovf_q),
    .br_load_i (br_load),
    .is_sync_o (is_sync)
  );

  trace_data_filter i_filt (
    .coll_i   (coll),
    .single_i (single_i),
    .write_i  (mem_write_i),
    .mode_i   (cfg_data_mode_i),
    .kind_o   (dt_kind)
  );

  assign slot_free = !valid_q || msg_ready_i;
  assign br_req    = br_valid_i && coll && cfg_br_en_i;
  assign dt_req    = mem_valid_i && (dt_kind != K_NONE);
  assign br_load   = br_req && slot_free;
  assign dt_load   = dt_req && slot_free && !br_req;
  assign drop      = (br_req && !slot_free) || (dt_req && !dt_load);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      kind_q     <= K_NONE;
      addr_q     <= '0;
      data_q     <= '0;
      last_tgt_q <= '0;
    end else if (br_load) begin
      valid_q    <= 1'b1;
      kind_q     <= is_sync ? K_BR_SYNC : K_BR_COMP;
      addr_q     <= is_sync ? br_tgt_i : br_tgt_i - last_tgt_q;
      data_q     <= DATA_W'(PAY_W'(br_src_i));
      last_tgt_q <= br_tgt_i;
    end else if (dt_load) begin
      valid_q <= 1'b1;
      kind_q  <= dt_kind;
      addr_q  <= (dt_kind == K_RD_DATA) ? '0 : mem_addr_i;
      data_q  <= (dt_kind == K_RD_ADDR || dt_kind == K_WR_ADDR) ? '0 : mem_data_i;
    end else if (msg_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // a drop in the same cycle outranks the clear, so the next branch is still sync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovf_q <= 1'b0;
    else if (drop)                ovf_q <= 1'b1;
    else if (br_load && is_sync)  ovf_q <= 1'b0;
  end

  assign msg_valid_o = valid_q;
  assign msg_kind_o  = kind_q;
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = data_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/trace_msg_gen_chk.sv
module trace_msg_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_br_en_i,
  input logic [1:0]  cfg_sync_sel_i,
  input logic        br_valid_i,
  input logic        mem_valid_i,
  input logic        msg_ready_i,
  input logic        msg_valid_o,
  input logic [2:0]  msg_kind_o,
  input logic [31:0] msg_addr_o,
  input logic [31:0] msg_data_o,
  input logic        ovf_o
);
  assert_hold_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_kind_o)
      && $stable(msg_addr_o) && $stable(msg_data_o)));

  assert_no_branch_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_br_en_i && !(msg_valid_o && !msg_ready_i))
      |=> !(msg_valid_o && (msg_kind_o == 3'd1 || msg_kind_o == 3'd2)));

  assert_every_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sync_sel_i == 2'd0 && br_valid_i && !(msg_valid_o && !msg_ready_i))
      |=> !(msg_valid_o && msg_kind_o == 3'd2));

  assert_ovf_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(br_valid_i || mem_valid_i));

  assert_ovf_clear_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_o) |-> (msg_valid_o && msg_kind_o == 3'd1));

  assert_kind_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_kind_o != 3'd0));
endmodule

bind trace_msg_gen trace_msg_gen_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_br_en_i    (cfg_br_en_i),
  .cfg_sync_sel_i (cfg_sync_sel_i),
  .br_valid_i     (br_valid_i),
  .mem_valid_i    (mem_valid_i),
  .msg_ready_i    (msg_ready_i),
  .msg_valid_o    (msg_valid_o),
  .msg_kind_o     (msg_kind_o),
  .msg_addr_o     (msg_addr_o),
  .msg_data_o     (msg_data_o),
  .ovf_o          (ovf_o)
);

// File: tb/test_trace_msg_gen.sv
module test_trace_msg_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_en = 1'b0, trc_on = 1'b0, trc_off = 1'b0, single = 1'b0;
  logic [1:0]  sync_sel = 2'd0;
  logic [2:0]  dmode = 3'd0;
  logic        br_v = 1'b0, mem_v = 1'b0, mem_w = 1'b0, ready = 1'b1;
  logic [31:0] br_src = '0, br_tgt = '0, mem_a = '0, mem_d = '0;
  logic        m_valid, ovf;
  logic [2:0]  m_kind;
  logic [31:0] m_addr, m_data;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] last_tgt = '0;

  always #2 clk = ~clk;

  trace_msg_gen i_trace_msg_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_br_en_i(br_en), .cfg_sync_sel_i(sync_sel),
    .cfg_data_mode_i(dmode), .trc_on_i(trc_on), .trc_off_i(trc_off), .single_i(single),
    .br_valid_i(br_v), .br_src_i(br_src), .br_tgt_i(br_tgt), .mem_valid_i(mem_v),
    .mem_write_i(mem_w), .mem_addr_i(mem_a), .mem_data_i(mem_d), .msg_ready_i(ready),
    .msg_valid_o(m_valid), .msg_kind_o(m_kind), .msg_addr_o(m_addr),
    .msg_data_o(m_data), .ovf_o(ovf)
  );

  // {mode, write, expected kind}; 0 = no message
  localparam logic [6:0] DVEC [16] = '{
    {3'd0,1'b0,3'd0}, {3'd0,1'b1,3'd0}, {3'd1,1'b0,3'd3}, {3'd1,1'b1,3'd0},
    {3'd2,1'b0,3'd0}, {3'd2,1'b1,3'd4}, {3'd3,1'b0,3'd3}, {3'd3,1'b1,3'd4},
    {3'd4,1'b0,3'd5}, {3'd4,1'b1,3'd0}, {3'd5,1'b0,3'd6}, {3'd5,1'b1,3'd0},
    {3'd6,1'b0,3'd0}, {3'd6,1'b1,3'd7}, {3'd7,1'b0,3'd6}, {3'd7,1'b1,3'd7}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_on();
    trc_on = 1'b1; @(negedge clk); trc_on = 1'b0;
  endtask

  task automatic pulse_off();
    trc_off = 1'b1; @(negedge clk); trc_off = 1'b0;
  endtask

  task automatic branch(input logic [31:0] s, input logic [31:0] t);
    br_v = 1'b1; br_src = s; br_tgt = t;
    @(negedge clk);
    br_v = 1'b0;
  endtask

  task automatic mem(input bit w, input logic [31:0] a, input logic [31:0] d, input bit sc);
    mem_v = 1'b1; mem_w = w; mem_a = a; mem_d = d; single = sc;
    @(negedge clk);
    mem_v = 1'b0; single = 1'b0;
  endtask

  task automatic exp_br(input bit sync, input logic [31:0] s, input logic [31:0] t, input string req);
    logic [31:0] ea;
    ea = sync ? t : t - last_tgt;
    chk(m_valid == 1'b1, req, 32'(m_valid), 32'd1);
    chk(m_kind == (sync ? 3'd1 : 3'd2), req, 32'(m_kind), sync ? 32'd1 : 32'd2);
    chk(m_addr == ea, sync ? "R6 addr" : "R7 delta", m_addr, ea);
    chk(m_data == s, sync ? "R6 src" : "R7 src", m_data, s);
    last_tgt = t;
  endtask

  task automatic exp_none(input string req);
    chk(m_valid == 1'b0, req, 32'(m_valid), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ea, ed;
    repeat (3) @(negedge clk);
    chk(m_valid == 1'b0, "R1 valid", 32'(m_valid), 32'd0);
    chk(ovf == 1'b0, "R1 ovf", 32'(ovf), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: collection off after reset
    br_en = 1'b1;
    branch(32'h10, 32'h100);
    exp_none("R2 off after reset");

    pulse_on();
    br_en = 1'b0;
    branch(32'h14, 32'h200);
    exp_none("R3 branch disabled");
    br_en = 1'b1;

    // R4/R5: period 4 -> S C C C S
    sync_sel = 2'd1;
    for (int i = 0; i < 5; i++) begin
      branch(32'h1000 + 32'(i), 32'h4000 + 32'(i * 40));
      exp_br(i == 0 || i == 4, 32'h1000 + 32'(i), 32'h4000 + 32'(i * 40), "R4 R5 period4");
    end

    // R5: every message sync
    sync_sel = 2'd0;
    for (int i = 0; i < 3; i++) begin
      branch(32'h2000 + 32'(i), 32'h8000 - 32'(i * 12));
      exp_br(1'b1, 32'h2000 + 32'(i), 32'h8000 - 32'(i * 12), "R5 all sync");
    end

    // R5: period 16, counting on from the last sync
    sync_sel = 2'd2;
    for (int i = 1; i <= 16; i++) begin
      branch(32'h3000 + 32'(i), 32'h9000 + 32'(i * 8));
      exp_br(i == 16, 32'h3000 + 32'(i), 32'h9000 + 32'(i * 8), "R5 period16");
    end
    branch(32'h3100, 32'h0000_0010);
    exp_br(1'b0, 32'h3100, 32'h0000_0010, "R7 wrap delta");

    // R4: restart after off/on
    pulse_off();
    branch(32'h3200, 32'h5555);
    exp_none("R2 off drops branch");
    pulse_on();
    branch(32'h3300, 32'h6666);
    exp_br(1'b1, 32'h3300, 32'h6666, "R4 restart");

    // R8: data mode table
    br_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      dmode = DVEC[i][6:4];
      mem(DVEC[i][3], 32'hA000 + 32'(i), 32'hD000 + 32'(i), 1'b0);
      if (DVEC[i][2:0] == 3'd0) begin
        exp_none("R8 untraced");
      end else begin
        ea = (DVEC[i][2:0] == 3'd5) ? 32'h0 : 32'hA000 + 32'(i);
        ed = (DVEC[i][2:0] == 3'd3 || DVEC[i][2:0] == 3'd4) ? 32'h0 : 32'hD000 + 32'(i);
        chk(m_valid && m_kind == DVEC[i][2:0], "R8 kind", 32'(m_kind), 32'(DVEC[i][2:0]));
        chk(m_addr == ea, "R8 addr", m_addr, ea);
        chk(m_data == ed, "R8 data", m_data, ed);
      end
      @(negedge clk);
    end

    // R9: single capture while off
    pulse_off();
    dmode = 3'd0;
    mem(1'b0, 32'hB000, 32'hC001, 1'b1);
    chk(m_valid && m_kind == 3'd6, "R9 single read", 32'(m_kind), 32'd6);
    chk(m_addr == 32'hB000 && m_data == 32'hC001, "R9 single fields", m_data, 32'hC001);
    mem(1'b1, 32'hB004, 32'hC002, 1'b1);
    chk(m_valid && m_kind == 3'd7, "R9 single write", 32'(m_kind), 32'd7);
    mem(1'b0, 32'hB008, 32'hC003, 1'b0);
    exp_none("R2 off no single");
    pulse_on();
    dmode = 3'd1;
    mem(1'b0, 32'hB00C, 32'hC004, 1'b1);
    chk(m_valid && m_kind == 3'd3, "R9 no effect when on", 32'(m_kind), 32'd3);
    chk(m_data == 32'h0, "R9 no data when on", m_data, 32'h0);
    @(negedge clk);

    // R10/R11: stall and overflow
    br_en = 1'b1;
    sync_sel = 2'd1;
    ready = 1'b0;
    branch(32'h4000, 32'hE000);
    exp_br(1'b1, 32'h4000, 32'hE000, "R10 first");
    branch(32'h4004, 32'hE100);
    chk(m_valid && m_kind == 3'd1 && m_addr == 32'hE000, "R10 held", m_addr, 32'hE000);
    chk(ovf == 1'b1, "R11 ovf set", 32'(ovf), 32'd1);
    @(negedge clk);
    chk(ovf == 1'b1, "R11 ovf sticky", 32'(ovf), 32'd1);
    ready = 1'b1;
    @(negedge clk);
    exp_none("R10 popped");
    branch(32'h4008, 32'hE200);
    exp_br(1'b1, 32'h4008, 32'hE200, "R11 forced sync");
    chk(ovf == 1'b0, "R11 ovf cleared", 32'(ovf), 32'd0);
    branch(32'h400C, 32'hE240);
    exp_br(1'b0, 32'h400C, 32'hE240, "R11 compressed after");

    // R12: collision
    dmode = 3'd7;
    br_v = 1'b1; br_src = 32'h5000; br_tgt = 32'hE300;
    mem_v = 1'b1; mem_w = 1'b0; mem_a = 32'hF000; mem_d = 32'h1234;
    @(negedge clk);
    br_v = 1'b0; mem_v = 1'b0;
    exp_br(1'b0, 32'h5000, 32'hE300, "R12 branch kept");
    chk(ovf == 1'b1, "R12 ovf", 32'(ovf), 32'd1);
    @(negedge clk);
    exp_none("R12 data dropped");
    branch(32'h5004, 32'hE400);
    exp_br(1'b1, 32'h5004, 32'hE400, "R11 sync after collision");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule